// File: doc/BRIEF.md
# Programmable Skew Clock Bank Generator

This block builds four banks of two clock outputs from a single fast timing clock. The fast clock runs at N times the nominal output frequency, so one fast-clock period is the skew unit. A phase counter walks from 0 to N−1 and restarts whenever the reference phase marker is seen. Each bank compares that phase against its own programmed offset. The result is a 50% duty-cycle output that leads or lags the reference by a whole number of skew units. On the two outer banks, the extreme control codes select a divided or an inverted output instead of a skew.

Every bank is set by two three-level selects, each carried on 2 bits. The range select picks N. The edge-polarity select decides on which reference edge the divided outputs change. All bank controls, the range and the polarity are captured only at a period boundary. A control change therefore never splits a period in two.

Top module: `skew_clk_banks`

## Requirements
- R1: Each three-level select is encoded as 00 = low, 01 = mid, 10 = high, and 11 (undriven) reads as mid. A bank whose two selects are both mid produces zero skew.
- R2: Bank b uses bank_ctl[4b+3:4b+2] as the high-order select (S1) and bank_ctl[4b+1:4b] as the low-order select (S0), forming idx = 3·rank(S1) + rank(S0), where low = 0, mid = 1 and high = 2. On banks 0 and 1 the skew is (idx − 4) units, giving −4 … +4.
- R3: On banks 2 and 3, idx 1 to 7 give a skew of 2·(idx − 4) units, giving −6 … +6.
- R4: The cycle after an edge that samples ref_mark high has phase 0. The phase then advances by one each cycle and wraps after N−1. A skew-s output is high in the cycles whose phase p satisfies (p − s) mod N < N/2, so a negative skew leads and a positive skew lags.
- R5: rng_sel 00 gives N = 44, 10 gives N = 16, and 01 or 11 gives N = 26.
- R6: idx 0 on banks 2 and 3 selects divide-by-2, and idx 8 on bank 2 selects divide-by-4. Both are taken from one 2-bit count (bit 0 for divide-by-2, bit 1 for divide-by-4). The count is 0 at reset and advances by one at each selected reference edge.
- R7: idx 8 on bank 3 gives the zero-skew waveform inverted, that is, high while phase ≥ N/2.
- R8: With edge_pol = 1, the count advances on entry to phase 0 and the divided outputs equal the count bits. With edge_pol = 0, it advances on entry to phase N/2 and the divided outputs are the complemented bits, so the rising edges of divide-by-2 and divide-by-4 coincide.
- R9: Both outputs of a bank, clk_out[2b] and clk_out[2b+1], always carry the same value.
- R10: bank_ctl, rng_sel and edge_pol are captured only on the edge that enters phase 0. A change at any other time takes effect at the next boundary.
- R11: While rst_n is low at a clock edge, all outputs go low, the phase goes to 0 and the divider count to 0. The captured settings become all-mid, N = 26 and edge_pol = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock, one period per skew unit |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_mark | input | 1 | Reference phase marker; restarts the phase at 0 |
| rng_sel | input | 2 | Three-level range select choosing N |
| edge_pol | input | 1 | Reference edge polarity for divided outputs |
| bank_ctl | input | 16 | Four banks of two 2-bit three-level selects |
| clk_out | output | 8 | Two identical clock outputs per bank |

## Verification
The bench sweeps every one of the sixteen 2-bit code pairs across all banks, all four range codes and both polarities, comparing every output cycle against an arithmetic phase model. It focuses on the negative skews, which must wrap to N − |s|. A design that mishandled the wrap would shift leading outputs by N or lose the 50% duty cycle. It also checks that the undriven code acts as mid, and a decoder that treated it as high would produce a wrong skew or a divided output. Directed runs change a control mid-period and restart the marker mid-period: an eager design would show a clipped pulse at the change instead of at the boundary. They also confirm that with falling-edge polarity the divide-by-2 and divide-by-4 rises coincide, which a design without the complement would get wrong every other edge. Output periods are measured for each range code to catch a wrong N.

// File: rtl/skew_clk_pkg.sv
// Shared encodings for the programmable skew clock bank generator.
// Assumes three-level inputs arrive already resolved to 2-bit codes.
package skew_clk_pkg;

    localparam int NUM_BANKS = 4;
    localparam int LVL_W     = 2;
    localparam int CTL_W     = 2 * LVL_W;
    localparam int DIV_W     = 2;
    localparam int MID_IDX   = 4;

    localparam logic [LVL_W-1:0] LVL_LOW  = 2'b00;
    localparam logic [LVL_W-1:0] LVL_MID  = 2'b01;
    localparam logic [LVL_W-1:0] LVL_HIGH = 2'b10;
    localparam logic [LVL_W-1:0] LVL_OPEN = 2'b11;

    typedef enum logic [1:0] {
        MODE_SKEW = 2'd0,
        MODE_DIV2 = 2'd1,
        MODE_DIV4 = 2'd2,
        MODE_INV  = 2'd3
    } out_mode_e;

    // Rank of a three-level select: low 0, high 2, mid or undriven 1.
    function automatic logic [1:0] lvl_rank(input logic [LVL_W-1:0] lvl);
        case (lvl)
            LVL_LOW:  return 2'd0;
            LVL_HIGH: return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction

    // Nine-way index of a bank control pair: 3*rank(S1) + rank(S0).
    function automatic logic [3:0] code_index(input logic [CTL_W-1:0] ctl);
        return 4'(3 * lvl_rank(ctl[CTL_W-1:LVL_W])) + 4'(lvl_rank(ctl[LVL_W-1:0]));
    endfunction

endpackage

// File: rtl/skew_phase_ctr.sv
// Phase counter and boundary capture of settings.
// Counts 0..N-1 on the fast clock and restarts on the reference marker.
// Settings are captured only on the edge entering phase 0.
// Assumes every selectable N is even and fits in PH_W bits.
module skew_phase_ctr
    import skew_clk_pkg::*;
#(
    parameter int N_LOW    = 44,
    parameter int N_MID    = 26,
    parameter int N_HIGH   = 16,
    parameter int PH_W     = 6,
    parameter int CTL_BITS = NUM_BANKS * CTL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_mark,
    input  logic [LVL_W-1:0]    rng_sel,
    input  logic                edge_pol,
    input  logic [CTL_BITS-1:0] ctl_in,
    output logic [PH_W-1:0]     ph_q,
    output logic [PH_W-1:0]     ph_n,
    output logic [PH_W-1:0]     n_q,
    output logic [PH_W-1:0]     n_n,
    output logic                pol_n,
    output logic [CTL_BITS-1:0] ctl_q,
    output logic [CTL_BITS-1:0] ctl_n
);

    localparam int                NB_CAP   = CTL_BITS / CTL_W;
    localparam logic [CTL_BITS-1:0] CTL_RST = {NB_CAP{LVL_MID, LVL_MID}};

    logic pol_q;
    logic boundary;

    // Map a range select to the number of fast cycles per period.
    function automatic logic [PH_W-1:0] range_len(input logic [LVL_W-1:0] sel);
        case (sel)
            LVL_LOW:  return PH_W'(N_LOW);
            LVL_HIGH: return PH_W'(N_HIGH);
            default:  return PH_W'(N_MID);
        endcase
    endfunction

    // Next phase and boundary-gated capture of settings.
    always_comb begin
        boundary = ref_mark || (ph_q == n_q - 1'b1);
        ph_n     = boundary ? '0 : ph_q + 1'b1;
        n_n      = boundary ? range_len(rng_sel) : n_q;
        pol_n    = boundary ? edge_pol : pol_q;
        ctl_n    = boundary ? ctl_in : ctl_q;
    end

    // Phase and settings registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            n_q   <= PH_W'(N_MID);
            pol_q <= 1'b1;
            ctl_q <= CTL_RST;
        end else begin
            ph_q  <= ph_n;
            n_q   <= n_n;
            pol_q <= pol_n;
            ctl_q <= ctl_n;
        end
    end

endmodule

// File: rtl/skew_div_ctr.sv
// Shared divider count for the divide-by-2 and divide-by-4 modes.
// Advances once per period on the selected reference edge: entry to
// phase 0 for rising polarity, entry to phase N/2 for falling polarity.
module skew_div_ctr
    import skew_clk_pkg::*;
#(
    parameter int PH_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  ph_n,
    input  logic [PH_W-1:0]  n_n,
    input  logic             pol_n,
    output logic [DIV_W-1:0] cnt_q,
    output logic [DIV_W-1:0] cnt_n
);

    logic edge_hit;

    // Detect the selected reference edge and step the count.
    always_comb begin
        edge_hit = pol_n ? (ph_n == '0) : (ph_n == (n_n >> 1));
        cnt_n    = edge_hit ? cnt_q + 1'b1 : cnt_q;
    end

    // Divider count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_n;
        end
    end

endmodule

// File: rtl/skew_bank_out.sv
// One output bank: decodes its nine-way control and forms the waveform.
// Banks 0-1 step one unit; banks 2-3 step two units and use the end
// codes for divide or invert. Works from next-state values so the
// registered output lines up with the phase register.
// Assumes the largest skew (6) is below the smallest N.
module skew_bank_out
    import skew_clk_pkg::*;
#(
    parameter int BANK = 0,
    parameter int PH_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  ph_n,
    input  logic [PH_W-1:0]  n_n,
    input  logic             pol_n,
    input  logic [DIV_W-1:0] cnt_n,
    input  logic [CTL_W-1:0] ctl_n,
    output logic             clk_q
);

    localparam bit COARSE = (BANK >= 2);

    out_mode_e       mode;
    logic [3:0]      idx;
    logic [3:0]      mag;
    logic            lag;
    logic [PH_W-1:0] half;
    logic [PH_W-1:0] s_mod;
    logic [PH_W-1:0] rel;
    logic            nxt;

    assign idx = code_index(ctl_n);

    if (!COARSE) begin : g_fine
        // Fine banks: offset of one unit per code step, always skew mode.
        always_comb begin
            mode = MODE_SKEW;
            lag  = (idx >= 4'(MID_IDX));
            mag  = lag ? idx - 4'(MID_IDX) : 4'(MID_IDX) - idx;
        end
    end else begin : g_coarse
        // Coarse banks: two units per step, end codes pick special modes.
        always_comb begin
            lag  = (idx >= 4'(MID_IDX));
            mag  = lag ? (idx - 4'(MID_IDX)) << 1 : (4'(MID_IDX) - idx) << 1;
            mode = MODE_SKEW;
            if (idx == 4'd0) begin
                mode = MODE_DIV2;
            end else if (idx == 4'd8) begin
                mode = (BANK == 2) ? MODE_DIV4 : MODE_INV;
            end
        end
    end

    // Phase distance from the programmed rising point, modulo N.
    always_comb begin
        half = n_n >> 1;
        if (mag == 4'd0) begin
            s_mod = '0;
        end else if (lag) begin
            s_mod = PH_W'(mag);
        end else begin
            s_mod = n_n - PH_W'(mag);
        end
        rel = (ph_n >= s_mod) ? ph_n - s_mod : ph_n + (n_n - s_mod);
    end

    // Select the waveform for the active mode.
    always_comb begin
        case (mode)
            MODE_DIV2: nxt = pol_n ? cnt_n[0] : ~cnt_n[0];
            MODE_DIV4: nxt = pol_n ? cnt_n[1] : ~cnt_n[1];
            MODE_INV:  nxt = (ph_n >= half);
            default:   nxt = (rel < half);
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
        end else begin
            clk_q <= nxt;
        end
    end

endmodule

// File: rtl/skew_clk_banks.sv
// Top of the programmable skew clock bank generator.
// One phase counter and one divider count are shared by four banks,
// each driving an identical pair of outputs.
// Assumes all N values are even and at least 16.
module skew_clk_banks
    import skew_clk_pkg::*;
#(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ref_mark,
    input  logic [LVL_W-1:0]             rng_sel,
    input  logic                         edge_pol,
    input  logic [NUM_BANKS*CTL_W-1:0]   bank_ctl,
    output logic [2*NUM_BANKS-1:0]       clk_out
);

    localparam int N_TOP = (N_LOW > N_MID) ? N_LOW : N_MID;
    localparam int N_MAX = (N_TOP > N_HIGH) ? N_TOP : N_HIGH;
    localparam int PH_W  = $clog2(N_MAX + 1);
    localparam int CTL_BITS = NUM_BANKS * CTL_W;

    logic [PH_W-1:0]     ph_q;
    logic [PH_W-1:0]     ph_n;
    logic [PH_W-1:0]     n_act;
    logic [PH_W-1:0]     n_n;
    logic                pol_n;
    logic [CTL_BITS-1:0] ctl_act;
    logic [CTL_BITS-1:0] ctl_n;
    logic [DIV_W-1:0]    dcnt_q;
    logic [DIV_W-1:0]    dcnt_n;
    logic [NUM_BANKS-1:0] bank_q;

    skew_phase_ctr #(
        .N_LOW    (N_LOW),
        .N_MID    (N_MID),
        .N_HIGH   (N_HIGH),
        .PH_W     (PH_W),
        .CTL_BITS (CTL_BITS)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_mark (ref_mark),
        .rng_sel  (rng_sel),
        .edge_pol (edge_pol),
        .ctl_in   (bank_ctl),
        .ph_q     (ph_q),
        .ph_n     (ph_n),
        .n_q      (n_act),
        .n_n      (n_n),
        .pol_n    (pol_n),
        .ctl_q    (ctl_act),
        .ctl_n    (ctl_n)
    );

    skew_div_ctr #(
        .PH_W (PH_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_n  (ph_n),
        .n_n   (n_n),
        .pol_n (pol_n),
        .cnt_q (dcnt_q),
        .cnt_n (dcnt_n)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        skew_bank_out #(
            .BANK (b),
            .PH_W (PH_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .ph_n  (ph_n),
            .n_n   (n_n),
            .pol_n (pol_n),
            .cnt_n (dcnt_n),
            .ctl_n (ctl_n[b*CTL_W +: CTL_W]),
            .clk_q (bank_q[b])
        );
        assign clk_out[2*b]     = bank_q[b];
        assign clk_out[2*b + 1] = bank_q[b];
    end

endmodule

// File: rtl/skew_clk_banks_chk.sv
// Checker for the skew clock bank generator, bound to the top module.
// Observes the outputs, the phase register, captured settings and the
// divider count.
module skew_clk_banks_chk #(
    parameter int PH_W     = 6,
    parameter int CTL_BITS = 16,
    parameter int OUT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ref_mark,
    input logic [OUT_W-1:0]    clk_out,
    input logic [PH_W-1:0]     ph,
    input logic [PH_W-1:0]     n_act,
    input logic [CTL_BITS-1:0] ctl_act,
    input logic [1:0]          dcnt
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (clk_out == '0)); // R11

    AST_MARK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ref_mark |=> (ph == '0)); // R4

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ph < n_act); // R4

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != '0) |-> ($stable(ctl_act) && $stable(n_act))); // R10

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dcnt != $past(dcnt)) |-> (dcnt == $past(dcnt) + 2'd1)); // R6

    AST_DIV_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dcnt != $past(dcnt)) |-> ((ph == '0) || (ph == (n_act >> 1)))); // R8

endmodule

bind skew_clk_banks skew_clk_banks_chk #(
    .PH_W     (PH_W),
    .CTL_BITS (CTL_BITS),
    .OUT_W    (2 * skew_clk_pkg::NUM_BANKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_mark (ref_mark),
    .clk_out  (clk_out),
    .ph       (ph_q),
    .n_act    (n_act),
    .ctl_act  (ctl_act),
    .dcnt     (dcnt_q)
);

// File: tb/skew_clk_banks_bench.sv
// Bench for skew_clk_banks: arithmetic phase model plus directed runs.
module skew_clk_banks_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_mark = 1'b0;
    logic [1:0]  rng_sel = 2'b01;
    logic        edge_pol = 1'b1;
    logic [15:0] bank_ctl = 16'h5555;
    logic [7:0]  clk_out;

    int checks = 0;
    int errors = 0;
    bit wd_hit = 1'b0;

    // Model state
    int         m_p = 0;
    int         m_n = 26;
    logic       m_pol = 1'b1;
    logic [15:0] m_ctl = 16'h5555;
    logic [1:0] m_cnt = 2'd0;
    bit         m_valid = 1'b0;
    string      tag_force = "";

    always #2 clk = ~clk;

    skew_clk_banks u_skew_clk_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_mark (ref_mark),
        .rng_sel  (rng_sel),
        .edge_pol (edge_pol),
        .bank_ctl (bank_ctl),
        .clk_out  (clk_out)
    );

    function automatic int rank(input logic [1:0] l);
        if (l == 2'b00) return 0;
        if (l == 2'b10) return 2;
        return 1;
    endfunction

    function automatic int n_of(input logic [1:0] r);
        if (r == 2'b00) return 44;
        if (r == 2'b10) return 16;
        return 26;
    endfunction

    function automatic logic exp_out(input int b);
        logic [3:0] c;
        int idx;
        int s;
        c = m_ctl[4*b +: 4];
        idx = 3 * rank(c[3:2]) + rank(c[1:0]);
        if (b >= 2 && idx == 0) return m_pol ? m_cnt[0] : !m_cnt[0];
        if (b == 2 && idx == 8) return m_pol ? m_cnt[1] : !m_cnt[1];
        if (b == 3 && idx == 8) return (m_p >= m_n / 2);
        s = (b < 2) ? idx - 4 : 2 * (idx - 4);
        return ((m_p - s + 4 * m_n) % m_n) < (m_n / 2);
    endfunction

    function automatic string tag_for(input int b);
        logic [3:0] c;
        int idx;
        if (tag_force != "") return tag_force;
        c = m_ctl[4*b +: 4];
        if (c[3:2] == 2'b11 || c[1:0] == 2'b11) return "R1";
        idx = 3 * rank(c[3:2]) + rank(c[1:0]);
        if (b < 2) return "R2";
        if (idx == 0) return "R6";
        if (idx == 8) return (b == 2) ? "R6" : "R7";
        return "R3";
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Reference model, updated on the same edges as the design.
    always @(posedge clk) begin
        int np;
        int nn;
        logic npol;
        logic [15:0] nctl;
        bit ev;
        if (!rst_n) begin
            m_p <= 0; m_n <= 26; m_pol <= 1'b1; m_ctl <= 16'h5555;
            m_cnt <= 2'd0; m_valid <= 1'b0;
        end else begin
            np = (ref_mark || m_p == m_n - 1) ? 0 : m_p + 1;
            nn = m_n; npol = m_pol; nctl = m_ctl;
            if (np == 0) begin
                nn = n_of(rng_sel); npol = edge_pol; nctl = bank_ctl;
            end
            ev = npol ? (np == 0) : (np == nn / 2);
            m_p <= np; m_n <= nn; m_pol <= npol; m_ctl <= nctl;
            if (ev) m_cnt <= m_cnt + 2'd1;
            m_valid <= 1'b1;
        end
    end

    // Compare every bank each cycle, away from the active edge.
    always @(negedge clk) begin
        if (m_valid && rst_n) begin
            for (int b = 0; b < 4; b++) begin
                chk(tag_for(b), $sformatf("bank %0d phase %0d", b, m_p), clk_out[2*b], exp_out(b));
                chk("R9", $sformatf("bank %0d pair", b), clk_out[2*b+1], clk_out[2*b]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mark();
        ref_mark = 1'b1;
        tick();
        ref_mark = 1'b0;
    endtask

    task automatic measure(input logic [1:0] r, input int expn);
        int cnt;
        logic prev;
        bank_ctl = 16'h5555; rng_sel = r; edge_pol = 1'b1;
        mark();
        prev = clk_out[0];
        cnt = 0;
        for (int g = 0; g < 200; g++) begin
            tick();
            cnt++;
            if (!prev && clk_out[0]) break;
            prev = clk_out[0];
        end
        checks++;
        if (cnt != expn) begin
            errors++;
            $display("FAIL R5 period rng=%0b actual=%0d expected=%0d", r, cnt, expn);
        end
    endtask

    task automatic run_all();
        int rises;
        logic p4, p6;
        // R11: reset state, with non-mid inputs present
        bank_ctl = 16'h0000; rng_sel = 2'b10;
        repeat (3) tick();
        chk("R11", "outputs in reset", |clk_out, 1'b0);
        tick();
        chk("R11", "outputs in reset", |clk_out, 1'b0);
        tag_force = "R11";
        rst_n = 1'b1;
        repeat (24) tick();
        tag_force = "";
        repeat (10) tick();

        // R5: period per range code
        measure(2'b00, 44);
        measure(2'b01, 26);
        measure(2'b10, 16);
        measure(2'b11, 26);

        // R10: mid-period control change waits for the boundary
        bank_ctl = 16'h5555; rng_sel = 2'b10; edge_pol = 1'b1;
        mark();
        tag_force = "R10";
        tick(); tick();
        bank_ctl = 16'h555A;
        tick();
        chk("R10", "bank 0 keeps old skew at phase 3", clk_out[0], 1'b1);
        repeat (14) tick();
        chk("R10", "bank 0 uses +4 at next phase 1", clk_out[0], 1'b0);
        repeat (20) tick();

        // R4: marker arriving mid-period restarts the phase
        tag_force = "R4";
        bank_ctl = 16'h1F93;
        mark();
        repeat (5) tick();
        mark();
        repeat (40) tick();
        tag_force = "";

        // Sweep every code, range and polarity
        for (int r = 0; r < 4; r++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int k = 0; k < 16; k++) begin
                    for (int b = 0; b < 4; b++) bank_ctl[4*b +: 4] = 4'((k + 5 * b) % 16);
                    rng_sel = 2'(r);
                    edge_pol = pol[0];
                    mark();
                    repeat (4 * n_of(2'(r)) + 2) tick();
                end
            end
        end

        // R8: falling polarity, divide-by-4 and divide-by-2 rise together
        tag_force = "R8";
        rng_sel = 2'b10; edge_pol = 1'b0; bank_ctl = 16'h0A55;
        mark();
        rises = 0;
        p4 = clk_out[4]; p6 = clk_out[6];
        for (int i = 0; i < 140; i++) begin
            tick();
            if (!p4 && clk_out[4]) begin
                rises++;
                chk("R8", "div2 rises with div4", !p6 && clk_out[6], 1'b1);
            end
            p4 = clk_out[4]; p6 = clk_out[6];
        end
        checks++;
        if (rises < 2) begin
            errors++;
            $display("FAIL R8 div4 rise count actual=%0d expected>=2", rises);
        end
        tag_force = "";
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        if (wd_hit) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule